// File: doc/BRIEF.md
# Host-Slave Parallel Mailbox

This block joins an external host processor to an embedded slave processor through three byte-wide registers. The host writes an inbound byte, the slave writes an outbound byte, and a shared status byte tells each side what is waiting. Every host write also records the host address bit. The slave can then tell whether the inbound byte is a command or plain data.

The host side is asynchronous: an address bit, an active-low chip select, and active-low read and write strobes. The block runs on the slave clock. It passes both host strobes through a synchroniser chain of `SYNC_STAGES` flops. It acts once on the rising edge of each synchronised access, so a strobe held for many cycles causes only one flag update. Host read data is driven combinationally. A separate enable output says when the host bus should be driven. On the slave side there is a plain select / write-enable register bus with a 2-bit register index.

Slave register index map:
- 0: inbound byte, read-only.
- 1: outbound byte, read/write.
- 2: status.
- 3: reads as zero.

Top module: `hsp_mailbox`

## Requirements
- R1: While chip select and read strobe are both low, `h_data_oe` is 1 and `h_data_o` carries the outbound byte when `h_addr` is 0 or the status byte when `h_addr` is 1. At all other times, including during host writes, `h_data_oe` is 0.
- R2: After reset the status byte reads 0x00.
- R3: A host write loads `h_data_i` into the inbound byte (read by the slave at index 0), whatever the value of `h_addr`. Status bit 3 takes the value of `h_addr` at that write: 1 means command, 0 means data.
- R4: Status bit 1 (inbound full) sets on a host write and clears when the slave reads index 0.
- R5: Status bit 0 (outbound full) sets when the slave writes index 1. It clears on a host read with `h_addr`=0, and a host read with `h_addr`=1 leaves it unchanged.
- R6: A slave write to index 2 updates status bits 7..4 and bit 2 from `s_wdata`, and leaves bits 3, 1 and 0 unchanged.
- R7: Each host access takes effect once. This holds even while a strobe stays low, and a flag cleared or set by the slave during that time is not overridden again. The effect is visible within `SYNC_STAGES`+2 clock cycles of the strobe falling.
- R8: When a flag's set event and its clear event fall in the same cycle, the set wins. This covers a host write against a slave read of index 0, and a slave write of index 1 against a host read of the outbound byte.
- R9: The slave reads back the outbound byte at index 1. A slave write to index 0 or 3 changes nothing, and index 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_addr | input | 1 | Host address bit (0 data port, 1 status/command) |
| h_cs_n | input | 1 | Host chip select, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_data_i | input | 8 | Host write data |
| h_data_o | output | 8 | Host read data |
| h_data_oe | output | 1 | Host data bus drive enable |
| s_sel | input | 1 | Slave access select |
| s_we | input | 1 | Slave write enable (0 read) |
| s_addr | input | 2 | Slave register index |
| s_wdata | input | 8 | Slave write data |
| s_rdata | output | 8 | Slave read data |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default 2. This places the rising-edge detection one cycle later than the default and tests that the bench's collision timing follows the parameter. With strobes held six cycles, the bench can perform slave accesses while a host access is still active. It can also place a slave access exactly in the cycle where the synchronised edge acts, which brings the set-versus-clear collisions and the once-per-access rule within reach.

// File: rtl/hsp_mailbox.sv
module hsp_mailbox #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_addr,
  input  logic       h_cs_n,
  input  logic       h_rd_n,
  input  logic       h_wr_n,
  input  logic [7:0] h_data_i,
  output logic [7:0] h_data_o,
  output logic       h_data_oe,
  input  logic       s_sel,
  input  logic       s_we,
  input  logic [1:0] s_addr,
  input  logic [7:0] s_wdata,
  output logic [7:0] s_rdata
);

  logic [SYNC_STAGES-1:0] wr_sync, rd_sync;
  logic       wr_prev, rd_prev;
  logic       wr_rise, rd_rise;
  logic [7:0] idr_q, odr_q;
  logic [4:0] usr_q;
  logic       cd_q, ibf_q, obf_q;
  logic [7:0] sts;

  wire h_wr_act = !h_cs_n && !h_wr_n;
  wire h_rd_odr = !h_cs_n && !h_rd_n && !h_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sync <= '0;
      rd_sync <= '0;
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      wr_sync <= {wr_sync[SYNC_STAGES-2:0], h_wr_act};
      rd_sync <= {rd_sync[SYNC_STAGES-2:0], h_rd_odr};
      wr_prev <= wr_sync[SYNC_STAGES-1];
      rd_prev <= rd_sync[SYNC_STAGES-1];
    end
  end

  assign wr_rise = wr_sync[SYNC_STAGES-1] && !wr_prev;
  assign rd_rise = rd_sync[SYNC_STAGES-1] && !rd_prev;

  wire s_rd_idr = s_sel && !s_we && (s_addr == 2'd0);
  wire s_wr_odr = s_sel &&  s_we && (s_addr == 2'd1);
  wire s_wr_sts = s_sel &&  s_we && (s_addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr_q <= '0;
      usr_q <= '0;
      cd_q  <= 1'b0;
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
    end else begin
      if (wr_rise) begin
        idr_q <= h_data_i;
        cd_q  <= h_addr;
      end
      if (wr_rise)       ibf_q <= 1'b1;
      else if (s_rd_idr) ibf_q <= 1'b0;
      if (s_wr_odr)      obf_q <= 1'b1;
      else if (rd_rise)  obf_q <= 1'b0;
      if (s_wr_sts)      usr_q <= {s_wdata[7:4], s_wdata[2]};
    end
  end

  always_ff @(posedge clk) begin
    if (s_wr_odr) odr_q <= s_wdata;
  end

  assign sts = {usr_q[4:1], cd_q, usr_q[0], ibf_q, obf_q};

  assign h_data_oe = !h_cs_n && !h_rd_n;
  assign h_data_o  = h_addr ? sts : odr_q;

  always_comb begin
    case (s_addr)
      2'd0:    s_rdata = idr_q;
      2'd1:    s_rdata = odr_q;
      2'd2:    s_rdata = sts;
      default: s_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/hsp_mailbox_chk.sv
module hsp_mailbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       h_addr,
  input logic       h_data_oe,
  input logic [7:0] h_data_o,
  input logic       s_sel,
  input logic       s_we,
  input logic [1:0] s_addr,
  input logic [7:0] sts,
  input logic [7:0] odr,
  input logic       wr_rise,
  input logic       rd_rise
);

  a_r2_reset_clear: assert property (@(posedge clk)
    !rst_n |=> sts == 8'h00);

  a_r1_odr_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (h_data_oe && !h_addr) |-> h_data_o == odr);

  a_r3_cd_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> (sts[1] && sts[3] == $past(h_addr)));

  a_r4_ibf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sel && !s_we && s_addr == 2'd0 && !wr_rise) |=> !sts[1]);

  a_r5_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sel && s_we && s_addr == 2'd1) |=> sts[0]);

  a_r6_ro_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sel && s_we && s_addr == 2'd2 && !wr_rise && !rd_rise)
      |=> $stable({sts[3], sts[1:0]}));

endmodule

bind hsp_mailbox hsp_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_data_oe(h_data_oe),
  .h_data_o(h_data_o), .s_sel(s_sel), .s_we(s_we), .s_addr(s_addr),
  .sts(sts), .odr(odr_q), .wr_rise(wr_rise), .rd_rise(rd_rise)
);

// File: tb/hsp_mailbox_tb_top.sv
`timescale 1ns/1ps
module hsp_mailbox_tb_top;
  localparam int S    = 3;
  localparam int HOLD = S + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_addr = 1'b0, h_cs_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1;
  logic [7:0] h_data_i = '0;
  logic [7:0] h_data_o;
  logic h_data_oe;
  logic s_sel = 1'b0, s_we = 1'b0;
  logic [1:0] s_addr = '0;
  logic [7:0] s_wdata = '0;
  logic [7:0] s_rdata;

  always #10 clk = ~clk;

  hsp_mailbox #(.SYNC_STAGES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_cs_n(h_cs_n),
    .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_data_i(h_data_i),
    .h_data_o(h_data_o), .h_data_oe(h_data_oe), .s_sel(s_sel),
    .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      case (it.kind)
        0: if (s_rdata !== it.exp) begin
             errors++;
             $display("FAIL %s slave read: actual=%h expected=%h", it.req, s_rdata, it.exp);
           end
        1: if (h_data_oe !== 1'b1 || h_data_o !== it.exp) begin
             errors++;
             $display("FAIL %s host read: actual oe=%b data=%h expected oe=1 data=%h",
                      it.req, h_data_oe, h_data_o, it.exp);
           end
        default: if (h_data_oe !== 1'b0) begin
             errors++;
             $display("FAIL %s host bus enable: actual=%b expected=0", it.req, h_data_oe);
           end
      endcase
    end
  end

  task automatic expect_item(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic slave_rd(logic [1:0] a, logic [7:0] exp, string req);
    tick();
    s_sel = 1'b1; s_we = 1'b0; s_addr = a;
    expect_item(0, exp, req);
    tick();
    s_sel = 1'b0;
  endtask

  task automatic slave_wr(logic [1:0] a, logic [7:0] d);
    tick();
    s_sel = 1'b1; s_we = 1'b1; s_addr = a; s_wdata = d;
    tick();
    s_sel = 1'b0; s_we = 1'b0;
  endtask

  task automatic host_wr(logic a, logic [7:0] d);
    tick();
    h_addr = a; h_data_i = d; h_cs_n = 1'b0; h_wr_n = 1'b0;
    expect_item(2, 8'h00, "R1");
    repeat (HOLD) @(posedge clk);
    #2; h_cs_n = 1'b1; h_wr_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic host_rd(logic a, logic [7:0] exp, string req);
    tick();
    h_addr = a; h_cs_n = 1'b0; h_rd_n = 1'b0;
    expect_item(1, exp, req);
    repeat (HOLD) @(posedge clk);
    #2; h_cs_n = 1'b1; h_rd_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R2 reset state, R1 idle bus
    expect_item(2, 8'h00, "R1");
    slave_rd(2'd2, 8'h00, "R2");

    // R3 / R4 data write
    host_wr(1'b0, 8'h5A);
    slave_rd(2'd2, 8'h02, "R4");
    slave_rd(2'd0, 8'h5A, "R3");
    slave_rd(2'd2, 8'h00, "R4");

    // R3 command write
    host_wr(1'b1, 8'hC3);
    slave_rd(2'd2, 8'h0A, "R3");
    slave_rd(2'd0, 8'hC3, "R3");
    slave_rd(2'd2, 8'h08, "R4");

    // R5 / R9 / R1 outbound path
    slave_wr(2'd1, 8'h96);
    slave_rd(2'd2, 8'h09, "R5");
    slave_rd(2'd1, 8'h96, "R9");
    host_rd(1'b0, 8'h96, "R1");
    slave_rd(2'd2, 8'h08, "R5");

    // R6 user bits, R5 status read does not clear
    slave_wr(2'd2, 8'hFF);
    slave_rd(2'd2, 8'hFC, "R6");
    slave_wr(2'd1, 8'h11);
    host_rd(1'b1, 8'hFD, "R1");
    slave_rd(2'd2, 8'hFD, "R5");
    slave_wr(2'd2, 8'h00);
    slave_rd(2'd2, 8'h09, "R6");

    // R9 ignored writes
    slave_wr(2'd0, 8'h77);
    slave_wr(2'd3, 8'h55);
    slave_rd(2'd0, 8'hC3, "R9");
    slave_rd(2'd3, 8'h00, "R9");
    slave_rd(2'd1, 8'h11, "R9");

    // R7 held write strobe: slave read mid-access is not undone
    tick();
    h_addr = 1'b0; h_data_i = 8'h3C; h_cs_n = 1'b0; h_wr_n = 1'b0;
    repeat (S + 2) tick();
    s_sel = 1'b1; s_we = 1'b0; s_addr = 2'd0;
    expect_item(0, 8'h3C, "R7");
    tick(); s_sel = 1'b0;
    repeat (HOLD) tick();
    h_cs_n = 1'b1; h_wr_n = 1'b1;
    repeat (4) tick();
    slave_rd(2'd2, 8'h01, "R7");

    // R7 held read strobe: slave write mid-access is not undone
    tick();
    h_addr = 1'b0; h_cs_n = 1'b0; h_rd_n = 1'b0;
    repeat (S + 2) tick();
    s_sel = 1'b1; s_we = 1'b1; s_addr = 2'd1; s_wdata = 8'h22;
    tick(); s_sel = 1'b0; s_we = 1'b0;
    repeat (HOLD) tick();
    h_cs_n = 1'b1; h_rd_n = 1'b1;
    repeat (4) tick();
    slave_rd(2'd2, 8'h01, "R7");

    // R8 outbound collision: clear obf first, then collide
    host_rd(1'b0, 8'h22, "R5");
    slave_rd(2'd2, 8'h00, "R5");
    tick();
    h_addr = 1'b0; h_cs_n = 1'b0; h_rd_n = 1'b0;
    repeat (S) @(posedge clk);
    #2; s_sel = 1'b1; s_we = 1'b1; s_addr = 2'd1; s_wdata = 8'h44;
    tick(); s_sel = 1'b0; s_we = 1'b0;
    repeat (HOLD) tick();
    h_cs_n = 1'b1; h_rd_n = 1'b1;
    repeat (4) tick();
    slave_rd(2'd2, 8'h01, "R8");

    // R8 inbound collision
    tick();
    h_addr = 1'b1; h_data_i = 8'h81; h_cs_n = 1'b0; h_wr_n = 1'b0;
    repeat (S) @(posedge clk);
    #2; s_sel = 1'b1; s_we = 1'b0; s_addr = 2'd0;
    tick(); s_sel = 1'b0;
    repeat (HOLD) tick();
    h_cs_n = 1'b1; h_wr_n = 1'b1;
    repeat (4) tick();
    slave_rd(2'd2, 8'h0B, "R8");
    slave_rd(2'd0, 8'h81, "R3");

    repeat (3) tick();
    finish_run();
  end
endmodule